// File: doc/BRIEF.md
# Banked Indirect Test-Register Gateway

This block sits on the slave side of an MII management register port. It exposes three management registers: a control word, a write-staging word and a read-result word. Through them, software reaches a set of hidden register banks, each 32 words deep. The hidden banks are locked out of reset. They open only after software writes an exact four-step toggle of the test-mode bit to the control word.

A typical access unlocks the banks and then issues one command through the control word. A read command loads the selected hidden word into the read-result register. A write command commits the staged word. The access then ends with a zero write to the control word, which locks the banks again. Bank 0 holds analog and DSP tuning words, bank 1 holds wake-up and low-power status, and bank 3 holds built-in self-test and PLL settings. Bank 2 has no storage.

The unlock tracker is a five-state machine:

- `UL_IDLE`: locked and waiting for a zero write.
- `UL_ZERO1`: one zero write seen.
- `UL_MODE1`: a test-mode-only write followed the zero.
- `UL_ZERO2`: a second zero write followed.
- `UL_OPEN`: a second test-mode-only write completed the pattern, and commands may execute.

The transitions, all taken on control-word writes, are:

- Start: `UL_IDLE` goes to `UL_ZERO1` on a zero write.
- Advance: `UL_ZERO1` goes to `UL_MODE1`, `UL_MODE1` goes to `UL_ZERO2`, and `UL_ZERO2` goes to `UL_OPEN`, each on the expected value.
- Restart: `UL_ZERO1` or `UL_ZERO2` goes to `UL_ZERO1` on a zero write.
- Break: any other locked state falls back to `UL_IDLE` on an unexpected value.
- Hold: `UL_OPEN` stays open on any write with the test-mode bit set.
- Close: `UL_OPEN` goes to `UL_IDLE` on any write with the test-mode bit clear, zero included.

Top module: `banked_test_gateway`

## Requirements
- R1: After reset, every hidden word holds 0, the tracker is locked, and management addresses 20, 21 and 23 all read 0.
- R2: The banks open only after four consecutive control writes (address 20) of 0x0000, 0x0400, 0x0000 and 0x0400. A zero write while partway through the pattern restarts it at the first step.
- R3: Any other value written to the control word while locked returns the tracker to `UL_IDLE`, so a command issued after it has no effect.
- R4: Read command: a control write has bit 15 = 1, bit 14 = 0, bit 10 = 1, the bank in bits 12:11 and the word address in bits 9:5. From the next cycle, address 21 returns the selected hidden word.
- R5: Write command: a control write has bit 14 = 1, bit 15 = 0, bit 10 = 1, the bank in bits 12:11 and the word address in bits 4:0. It commits the value last written to address 23 into the selected hidden word.
- R6: While open, a control write with bit 10 clear (zero included) locks the banks and performs no action. Address 21 reads 0 whenever the banks are locked.
- R7: A read or write command written while locked is ignored: no hidden word changes, and the read result is not reloaded.
- R8: Bank 2 has no storage. Writes to it are dropped, and reads from it load 0.
- R9: A control write with both bits 15 and 14 set performs no action, even while open.
- R10: Bit 12 of bank 1, word 0x0C reads the level of the `lpi_status` input at the read command. The other bits of that word are stored normally.
- R11: Addresses 20 and 23 read back the last value written to them. Any management address other than 20, 21 and 23 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_we | input | 1 | Management register write strobe |
| mgmt_waddr | input | 5 | Management write address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_raddr | input | 5 | Management read address |
| mgmt_rdata | output | 16 | Management read data, combinational from `mgmt_raddr` |
| lpi_status | input | 1 | Live status level shown in bank 1, word 0x0C, bit 12 |

## Verification
Two actions can coincide in one control-word write: a valid command executing and the tracker deciding whether the banks stay open. A write with bit 10 clear but with a command bit set tests both at once. The bench drives such a write while open and then issues a correctly formed read. The read must return 0 because the banks have locked. The same collision is judged for the both-bits case, where the latched result must stay unchanged while the tracker stays open.

// File: rtl/gw_pkg.sv
package gw_pkg;
    typedef enum logic [2:0] {
        UL_IDLE,
        UL_ZERO1,
        UL_MODE1,
        UL_ZERO2,
        UL_OPEN
    } ul_state_t;

    localparam int ADDR_CTL   = 20;
    localparam int ADDR_RDATA = 21;
    localparam int ADDR_WDATA = 23;

    localparam int CTL_RD_BIT   = 15;
    localparam int CTL_WR_BIT   = 14;
    localparam int CTL_BANK_LO  = 11;
    localparam int CTL_TM_BIT   = 10;
    localparam int CTL_RADDR_LO = 5;
    localparam int CTL_WADDR_LO = 0;
endpackage

// File: rtl/gw_unlock_fsm.sv
module gw_unlock_fsm
    import gw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [DW-1:0] ctl_data,
    output logic          is_open
);
    localparam logic [DW-1:0] TM_ONLY = DW'(1) << CTL_TM_BIT;

    ul_state_t state_q, state_d;
    logic      is_zero, is_tm_only, tm_set;

    assign is_zero    = (ctl_data == '0);
    assign is_tm_only = (ctl_data == TM_ONLY);
    assign tm_set     = ctl_data[CTL_TM_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ctl_we) begin
            unique case (state_q)
                UL_IDLE:  state_d = is_zero ? UL_ZERO1 : UL_IDLE;
                UL_ZERO1: state_d = is_tm_only ? UL_MODE1 : (is_zero ? UL_ZERO1 : UL_IDLE);
                UL_MODE1: state_d = is_zero ? UL_ZERO2 : UL_IDLE;
                UL_ZERO2: state_d = is_tm_only ? UL_OPEN : (is_zero ? UL_ZERO1 : UL_IDLE);
                UL_OPEN:  state_d = tm_set ? UL_OPEN : UL_IDLE;
                default:  state_d = UL_IDLE;
            endcase
        end
    end

    always_comb begin
        is_open = (state_q == UL_OPEN);
    end

    AST_OPEN_NEEDS_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_open) |-> $past(ctl_we && is_tm_only)); // R2
    AST_BREAK_STAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !is_open && !is_zero && !is_tm_only) |=> !is_open); // R3
    AST_ZERO_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && is_zero) |=> !is_open); // R6
endmodule

// File: rtl/gw_cmd_decode.sv
module gw_cmd_decode
    import gw_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 5,
    parameter int BW = 2
) (
    input  logic          ctl_we,
    input  logic [DW-1:0] ctl_data,
    input  logic          is_open,
    output logic          do_read,
    output logic          do_write,
    output logic [BW-1:0] bank,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] waddr
);
    logic live, rd_bit, wr_bit;

    assign live   = ctl_we && is_open && ctl_data[CTL_TM_BIT];
    assign rd_bit = ctl_data[CTL_RD_BIT];
    assign wr_bit = ctl_data[CTL_WR_BIT];

    always_comb begin
        do_read  = live && rd_bit && !wr_bit;
        do_write = live && wr_bit && !rd_bit;
        bank     = ctl_data[CTL_BANK_LO +: BW];
        raddr    = ctl_data[CTL_RADDR_LO +: AW];
        waddr    = ctl_data[CTL_WADDR_LO +: AW];
    end

    always_comb begin
        AST_ONE_COMMAND: assert (!(do_read && do_write)); // R9
    end
endmodule

// File: rtl/gw_bank_store.sv
module gw_bank_store #(
    parameter int DW          = 16,
    parameter int NUM_BANKS   = 4,
    parameter int DEPTH       = 32,
    parameter int UNIMPL_BANK = 2,
    parameter int STAT_BANK   = 1,
    parameter int STAT_WORD   = 12,
    parameter int STAT_BIT    = 12,
    localparam int BW = $clog2(NUM_BANKS),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] wbank,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [BW-1:0] rbank,
    input  logic [AW-1:0] raddr,
    input  logic          status_in,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (b == UNIMPL_BANK) begin : g_empty
            assign bank_rd[b] = '0;
        end else begin : g_mem
            logic [DW-1:0] mem [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                end else if (we && (wbank == BW'(b))) begin
                    mem[waddr] <= wdata;
                end
            end
            assign bank_rd[b] = mem[raddr];
        end
    end

    always_comb begin
        rdata = bank_rd[rbank];
        if ((rbank == BW'(STAT_BANK)) && (raddr == AW'(STAT_WORD)))
            rdata[STAT_BIT] = status_in;
    end
endmodule

// File: rtl/banked_test_gateway.sv
module banked_test_gateway
    import gw_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 5,
    parameter int NUM_BANKS = 4,
    parameter int DEPTH     = 32,
    localparam int BW  = $clog2(NUM_BANKS),
    localparam int HAW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mgmt_we,
    input  logic [AW-1:0] mgmt_waddr,
    input  logic [DW-1:0] mgmt_wdata,
    input  logic [AW-1:0] mgmt_raddr,
    output logic [DW-1:0] mgmt_rdata,
    input  logic          lpi_status
);
    localparam logic [AW-1:0] A_CTL = AW'(ADDR_CTL);
    localparam logic [AW-1:0] A_RD  = AW'(ADDR_RDATA);
    localparam logic [AW-1:0] A_WD  = AW'(ADDR_WDATA);

    logic [DW-1:0]  ctl_q, stage_q, rlatch_q, store_rdata;
    logic           ctl_we, stage_we, is_open, do_read, do_write;
    logic [BW-1:0]  bank;
    logic [HAW-1:0] raddr, waddr;

    assign ctl_we   = mgmt_we && (mgmt_waddr == A_CTL);
    assign stage_we = mgmt_we && (mgmt_waddr == A_WD);

    gw_unlock_fsm #(.DW(DW)) u_unlock (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(mgmt_wdata), .is_open(is_open)
    );

    gw_cmd_decode #(.DW(DW), .AW(HAW), .BW(BW)) u_decode (
        .ctl_we(ctl_we), .ctl_data(mgmt_wdata), .is_open(is_open),
        .do_read(do_read), .do_write(do_write), .bank(bank), .raddr(raddr), .waddr(waddr)
    );

    gw_bank_store #(.DW(DW), .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(do_write), .wbank(bank), .waddr(waddr), .wdata(stage_q),
        .rbank(bank), .raddr(raddr), .status_in(lpi_status), .rdata(store_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            stage_q  <= '0;
            rlatch_q <= '0;
        end else begin
            if (ctl_we)   ctl_q    <= mgmt_wdata;
            if (stage_we) stage_q  <= mgmt_wdata;
            if (do_read)  rlatch_q <= store_rdata;
        end
    end

    always_comb begin
        unique case (mgmt_raddr)
            A_CTL:   mgmt_rdata = ctl_q;
            A_WD:    mgmt_rdata = stage_q;
            A_RD:    mgmt_rdata = is_open ? rlatch_q : '0;
            default: mgmt_rdata = '0;
        endcase
    end

    AST_LOCKED_CMD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !is_open) |=> $stable(rlatch_q)); // R7
    AST_DUAL_CMD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && mgmt_wdata[CTL_RD_BIT] && mgmt_wdata[CTL_WR_BIT]) |=> $stable(rlatch_q)); // R9
    AST_BANK2_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (do_read && bank == BW'(2)) |=> (rlatch_q == '0)); // R8
    AST_LOCKED_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open && mgmt_raddr == A_RD) |-> (mgmt_rdata == '0)); // R6
endmodule

// File: tb/banked_test_gateway_test.sv
module banked_test_gateway_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_we = 1'b0;
    logic [4:0]  mgmt_waddr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic [4:0]  mgmt_raddr = '0;
    logic [15:0] mgmt_rdata;
    logic        lpi_status = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    banked_test_gateway uut (
        .clk(clk), .rst_n(rst_n), .mgmt_we(mgmt_we), .mgmt_waddr(mgmt_waddr),
        .mgmt_wdata(mgmt_wdata), .mgmt_raddr(mgmt_raddr), .mgmt_rdata(mgmt_rdata),
        .lpi_status(lpi_status)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic mwr(input logic [4:0] a, input logic [15:0] d);
        mgmt_we = 1'b1; mgmt_waddr = a; mgmt_wdata = d;
        @(posedge clk); #1;
        mgmt_we = 1'b0;
    endtask

    task automatic mrd(input logic [4:0] a, output logic [15:0] d);
        mgmt_raddr = a; #1; d = mgmt_rdata;
    endtask

    task automatic unlock();
        mwr(20, 16'h0000); mwr(20, 16'h0400); mwr(20, 16'h0000); mwr(20, 16'h0400);
    endtask

    function automatic logic [15:0] cmd_rd(input int b, input int a);
        return 16'h8400 | 16'(b << 11) | 16'(a << 5);
    endfunction

    function automatic logic [15:0] cmd_wr(input int b, input int a);
        return 16'h4400 | 16'(b << 11) | 16'(a);
    endfunction

    function automatic logic [15:0] pat(input int b, input int a);
        return 16'((b + 1) * 16'h1357) ^ 16'(a * 16'h0421) ^ 16'h8000;
    endfunction

    function automatic logic [15:0] expect_word(input int b, input int a, input logic [15:0] v, input logic lpi);
        logic [15:0] r;
        if (b == 2) return 16'h0000;
        r = v;
        if (b == 1 && a == 12) r[12] = lpi;
        return r;
    endfunction

    task automatic hwrite(input int b, input int a, input logic [15:0] v);
        unlock(); mwr(23, v); mwr(20, cmd_wr(b, a)); mwr(20, 16'h0000);
    endtask

    task automatic hread(input int b, input int a, output logic [15:0] d);
        unlock(); mwr(20, cmd_rd(b, a)); mrd(21, d); mwr(20, 16'h0000);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        mrd(20, d); check("R1 ctl reset", d, 16'h0000);
        mrd(21, d); check("R1 result reset", d, 16'h0000);
        mrd(23, d); check("R1 stage reset", d, 16'h0000);
        hread(0, 7, d); check("R1 hidden reset", d, 16'h0000);

        mwr(23, 16'h1234); mrd(23, d); check("R11 stage readback", d, 16'h1234);
        mrd(20, d); check("R11 ctl readback", d, 16'h0000);
        mwr(5, 16'hFFFF); mrd(5, d); check("R11 other addr zero", d, 16'h0000);

        // Sweep: write every word of every bank (R5, R8), then read all back (R4, R10)
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) hwrite(b, a, pat(b, a));
        lpi_status = 1'b1;
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < 32; a++) begin
                hread(b, a, d);
                check(b == 2 ? "R8 bank2 zero" : (b == 1 && a == 12) ? "R10 status hi" : "R4 R5 sweep",
                      d, expect_word(b, a, pat(b, a), 1'b1));
            end
        lpi_status = 1'b0;
        hread(1, 12, d); check("R10 status lo", d, expect_word(1, 12, pat(1, 12), 1'b0));

        // R2 restart: 0,0,TM,0,TM opens
        mwr(20, 16'h0000); mwr(20, 16'h0000); mwr(20, 16'h0400); mwr(20, 16'h0000); mwr(20, 16'h0400);
        mwr(20, cmd_rd(3, 27)); mrd(21, d); check("R2 restart opens", d, pat(3, 27));
        mwr(20, 16'h0000);

        // R3 broken pattern
        mwr(20, 16'h0000); mwr(20, 16'h0400); mwr(20, 16'h0401); mwr(20, 16'h0400);
        mwr(20, cmd_rd(3, 28)); mrd(21, d); check("R3 broken locked", d, 16'h0000);
        mwr(20, 16'h0000); mwr(20, 16'h0400); mwr(20, 16'h0400); mwr(20, 16'h0000);
        mwr(20, cmd_rd(3, 28)); mrd(21, d); check("R3 short pattern locked", d, 16'h0000);
        mwr(20, 16'h0000);

        // R6 closed by zero; locked result reads zero
        unlock(); mwr(20, cmd_rd(0, 3)); mwr(20, 16'h0000);
        mrd(21, d); check("R6 closed reads zero", d, 16'h0000);
        mwr(20, cmd_rd(0, 3)); mrd(21, d); check("R6 cmd after close", d, 16'h0000);
        // R6 bit 10 clear with read bit, then valid-looking read must be locked
        unlock(); mwr(20, 16'h8000 | 16'(4 << 5)); mwr(20, cmd_rd(0, 4));
        mrd(21, d); check("R6 tm clear locks", d, 16'h0000);
        mwr(20, 16'h0000);

        // R7 locked write ignored
        mwr(23, 16'hDEAD); mwr(20, cmd_wr(0, 9));
        hread(0, 9, d); check("R7 locked write dropped", d, pat(0, 9));

        // R9 both bits: no write, no reload
        unlock(); mwr(20, cmd_rd(0, 10)); mwr(23, 16'hBEEF);
        mwr(20, 16'hC400 | 16'(11 << 5) | 16'd10);
        mrd(21, d); check("R9 result unchanged", d, pat(0, 10));
        mwr(20, 16'h0000);
        hread(0, 10, d); check("R9 no write", d, pat(0, 10));

        // R5 overwrite and R8 drop
        hwrite(3, 29, 16'h0005); hread(3, 29, d); check("R5 overwrite", d, 16'h0005);
        hwrite(2, 0, 16'h7777); hread(2, 0, d); check("R8 bank2 dropped", d, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule